// File: doc/BRIEF.md
# APB UART Register Front-End

This block is the software-facing side of a UART. A processor reaches it through an APB slave port with a 20-byte window that holds a data register, a status register and a control register, plus two reserved slots. Received bytes arrive on a byte-stream input, grouped into bursts, and are kept in a receive FIFO until software reads the data register. Bytes that software writes to the data register leave on a byte-stream output. Serial bit timing, baud scaling, parity, flow control and loopback belong to other blocks.

A burst announces its length on its first beat. The block takes the whole burst only if receive is enabled and the FIFO has room for all of it. Otherwise it drops every byte of the burst. Each stored byte and each sent byte can raise a one-cycle pulse on a single shared interrupt line, depending on two control bits. The transmit sink is taken to be always ready, so both transmit-empty status flags stay set.

Top module: `uart_regfront`

## Requirements
- R1: After reset the status word reads 0x0000_0006, the control word reads 0, the receive FIFO is empty and `rx_space` equals DEPTH.
- R2: Offsets decode as follows: 0x00 and 0x03 select data, 0x04 selects status and 0x08 selects control. Reads of 0x0C, 0x10 and any other offset return 0, and writes to them change nothing. `pready` is always 1 and `pslverr` is always 0.
- R3: A write to control replaces all 32 bits, and a read of control returns the stored word.
- R4: Received bytes are dropped while control bit 0 (receive enable) is 0.
- R5: The first beat of a burst (`rx_first`=1) carries its length in `rx_len`. The burst is stored only if that length is at most the free space. Otherwise every byte of the burst is dropped, and at most `rx_len` bytes are ever stored from one burst.
- R6: A read of data at 0x00 or 0x03 returns the oldest byte in `prdata[7:0]`, with the upper bits 0, and removes that byte. A read of an empty FIFO returns 0 and removes nothing.
- R7: Status bits: bit0 is set while the FIFO holds data, bit1 and bit2 always read 1, bit8 is set when occupancy is at least DEPTH/2, bit10 is set when the FIFO is full, and all other bits read 0.
- R8: A write to data (0x00 or 0x03) while control bit 1 (transmit enable) is 1 raises `tx_valid` for exactly one cycle, on the cycle after the access, with `tx_data` = `pwdata[7:0]`. With that bit at 0 the write has no effect.
- R9: `irq` pulses for one cycle, one cycle after each stored byte when control bit 2 is 1, and one cycle after each sent byte when control bit 3 is 1.
- R10: `rx_space` always equals DEPTH minus the FIFO occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| rx_valid | input | 1 | Received byte present |
| rx_first | input | 1 | Beat is the first of a burst |
| rx_len | input | $clog2(DEPTH+1) | Burst length, sampled on the first beat |
| rx_data | input | 8 | Received byte |
| rx_space | output | $clog2(DEPTH+1) | Free receive FIFO entries |
| tx_valid | output | 1 | One-cycle strobe for an outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Shared interrupt pulse |

## Verification
Read data and status reflect the state before the current access and appear combinationally in the APB access phase. A pop caused by that read shows up only from the next access onward. `tx_valid` and `irq` are registered, so each is due exactly one cycle after the access or received byte that caused it. The bench checks them with monitors that sample on the falling edge: the transmit monitor pops an expected-byte queue that the write task filled, and the interrupt monitor counts pulses against a model total that is compared after each burst or write has settled. FIFO occupancy effects are checked through `rx_space` and status reads issued after the burst task has released the input.

// File: rtl/uart_rf_pkg.sv
// Package: shared offsets and bit positions of the UART register front-end.
// Assumes byte addressing within a 20-byte window.
package uart_rf_pkg;
    localparam int OFS_DATA     = 0;
    localparam int OFS_DATA_B3  = 3;
    localparam int OFS_STATUS   = 4;
    localparam int OFS_CONTROL  = 8;

    localparam int ST_READY     = 0;
    localparam int ST_TSHIFT_MT = 1;
    localparam int ST_TFIFO_MT  = 2;
    localparam int ST_RX_HALF   = 8;
    localparam int ST_RX_FULL   = 10;

    localparam int CT_RX_EN     = 0;
    localparam int CT_TX_EN     = 1;
    localparam int CT_RX_IRQ    = 2;
    localparam int CT_TX_IRQ    = 3;
endpackage

// File: rtl/uart_rf_fifo.sv
// Receive FIFO: circular byte store with an occupancy counter.
// Assumes push never arrives while full (the admit stage guarantees it).
// The head byte is presented combinationally.
module uart_rf_fifo #(
    parameter int DEPTH = 1024,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write, no reset needed since pointers define validity
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head = mem[rd_ptr];

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) |-> !push);
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !pop);
endmodule

// File: rtl/uart_rf_rx_admit.sv
// Receive admission: decides on the first beat of a burst whether the whole
// burst fits and receive is enabled, then passes at most that many bytes.
// Assumes rx_len is meaningful only when rx_first is high.
module uart_rf_rx_admit #(
    parameter int DEPTH = 1024,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rx_first,
    input  logic [CW-1:0] rx_len,
    input  logic          rx_en,
    input  logic [CW-1:0] space,
    output logic          push
);
    logic [CW-1:0] remain_q;
    logic          fits;

    // Whole-burst fit test against free space at the first beat
    always_comb fits = rx_en && (rx_len != '0) && (rx_len <= space);

    // Push one byte per beat while the burst still has admitted bytes
    always_comb begin
        if (!rx_valid || !rx_en) push = 1'b0;
        else if (rx_first)       push = fits;
        else                     push = (remain_q != '0);
    end

    // Track admitted bytes still to come in the current burst
    always_ff @(posedge clk) begin
        if (!rst_n)                       remain_q <= '0;
        else if (rx_valid && rx_first)    remain_q <= fits ? rx_len - 1'b1 : '0;
        else if (push)                    remain_q <= remain_q - 1'b1;
    end

    a_r4_disabled_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_en) |-> !push);
    a_r5_reject_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_first && !push) |=> (rx_valid && !rx_first) |-> !push);
endmodule

// File: rtl/uart_rf_tx_irq.sv
// Transmit strobe and shared interrupt: registers the outgoing byte and
// merges receive and transmit events into one-cycle interrupt pulses.
// Assumes the transmit sink always accepts.
module uart_rf_tx_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       send,
    input  logic [7:0] send_byte,
    input  logic       rx_push,
    input  logic       rx_irq_en,
    input  logic       tx_irq_en,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       irq
);
    // Present the outgoing byte for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= send;
            if (send) tx_data <= send_byte;
        end
    end

    // One shared pulse for either enabled event
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (rx_push && rx_irq_en) || (send && tx_irq_en);
    end

    a_r8_tx_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);
    a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(rx_push || send));
endmodule

// File: rtl/uart_regfront.sv
// UART register front-end on APB: decodes a 20-byte window, reads and
// writes data, status and control, and connects the receive admission,
// FIFO and transmit/interrupt stages. Zero wait states, never errors.
module uart_regfront
    import uart_rf_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = 5,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic [CW-1:0]     rx_len,
    input  logic [7:0]        rx_data,
    output logic [CW-1:0]     rx_space,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    logic [31:0]   ctrl_q;
    logic [31:0]   status;
    logic [CW-1:0] count;
    logic [7:0]    head;
    logic          acc_rd, acc_wr, sel_data, sel_stat, sel_ctrl;
    logic          pop, push, send, empty;

    // Access phase qualifiers and offset decode
    always_comb begin
        acc_rd   = psel && penable && !pwrite;
        acc_wr   = psel && penable && pwrite;
        sel_data = (paddr == ADDR_W'(OFS_DATA)) || (paddr == ADDR_W'(OFS_DATA_B3));
        sel_stat = (paddr == ADDR_W'(OFS_STATUS));
        sel_ctrl = (paddr == ADDR_W'(OFS_CONTROL));
    end

    assign empty    = (count == '0);
    assign rx_space = CW'(DEPTH) - count;
    assign pop      = acc_rd && sel_data && !empty;
    assign send     = acc_wr && sel_data && ctrl_q[CT_TX_EN];
    assign pready   = 1'b1;
    assign pslverr  = 1'b0;

    // Status word built from live occupancy
    always_comb begin
        status               = '0;
        status[ST_READY]     = !empty;
        status[ST_TSHIFT_MT] = 1'b1;
        status[ST_TFIFO_MT]  = 1'b1;
        status[ST_RX_HALF]   = (count >= CW'(DEPTH / 2));
        status[ST_RX_FULL]   = (count == CW'(DEPTH));
    end

    // Read data multiplexer
    always_comb begin
        prdata = '0;
        if (acc_rd) begin
            if (sel_data && !empty) prdata = {24'b0, head};
            else if (sel_stat)      prdata = status;
            else if (sel_ctrl)      prdata = ctrl_q;
        end
    end

    // Control register, replaced whole on write
    always_ff @(posedge clk) begin
        if (!rst_n)                 ctrl_q <= '0;
        else if (acc_wr && sel_ctrl) ctrl_q <= pwdata;
    end

    uart_rf_rx_admit #(.DEPTH(DEPTH)) admit_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first),
        .rx_len(rx_len), .rx_en(ctrl_q[CT_RX_EN]), .space(rx_space), .push(push)
    );

    uart_rf_fifo #(.DEPTH(DEPTH), .W(8)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(rx_data),
        .pop(pop), .head(head), .count(count)
    );

    uart_rf_tx_irq txirq_i (
        .clk(clk), .rst_n(rst_n), .send(send), .send_byte(pwdata[7:0]),
        .rx_push(push), .rx_irq_en(ctrl_q[CT_RX_IRQ]), .tx_irq_en(ctrl_q[CT_TX_IRQ]),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && sel_data && empty) |-> (prdata == 32'b0));
    a_r10_space_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(rx_space));
    a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr && sel_ctrl) |=> $stable(ctrl_q));
endmodule

// File: tb/uart_regfront_tb.sv
// Scoreboard bench: driver tasks queue expected bytes and interrupt totals,
// monitors compare transmit strobes and count interrupt pulses.
module uart_regfront_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int ADDR_W     = 5;
    localparam int CW         = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic pready, pslverr;
    logic rx_valid = 0, rx_first = 0;
    logic [CW-1:0] rx_len = '0, rx_space;
    logic [7:0] rx_data = '0, tx_data;
    logic tx_valid, irq;

    int checks = 0, errors = 0;
    int irq_seen = 0, irq_exp = 0;
    int model_cnt = 0;
    logic [31:0] model_ctrl = '0;
    logic [7:0] rx_q[$];
    logic [7:0] tx_q[$];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regfront #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .rx_valid(rx_valid), .rx_first(rx_first),
        .rx_len(rx_len), .rx_data(rx_data), .rx_space(rx_space),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Monitor: transmit strobes against queued bytes, interrupt pulse count
    always @(negedge clk) begin
        if (rst_n && irq) irq_seen++;
        if (rst_n && tx_valid) begin
            if (tx_q.size() == 0) check("R8 unexpected tx", {24'b0, tx_data}, 32'hFFFF_FFFF);
            else check("R8 tx byte", {24'b0, tx_data}, {24'b0, tx_q.pop_front()});
        end
    end

    task automatic apb_write(input int addr, input logic [31:0] d);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 1; paddr = ADDR_W'(addr); pwdata = d;
        @(posedge clk); #1; penable = 1;
        @(posedge clk); #1; psel = 0; penable = 0; pwrite = 0;
        if (addr == 8) model_ctrl = d;
        if ((addr == 0 || addr == 3) && model_ctrl[1]) begin
            tx_q.push_back(d[7:0]);
            if (model_ctrl[3]) irq_exp++;
        end
    endtask

    task automatic apb_read(input int addr, output logic [31:0] d);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 0; paddr = ADDR_W'(addr);
        @(posedge clk); #1; penable = 1;
        #2 d = prdata;
        if (pready !== 1'b1 || pslverr !== 1'b0)
            check("R2 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
        @(posedge clk); #1; psel = 0; penable = 0;
    endtask

    task automatic rx_burst(input int n, input logic [7:0] base);
        bit take;
        take = model_ctrl[0] && (n <= DEPTH - model_cnt);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            rx_valid = 1; rx_first = (i == 0); rx_len = CW'(n); rx_data = base + 8'(i);
            if (take) begin
                rx_q.push_back(base + 8'(i));
                model_cnt++;
                if (model_ctrl[2]) irq_exp++;
            end
        end
        @(posedge clk); #1; rx_valid = 0; rx_first = 0;
        repeat (2) @(posedge clk);
    endtask

    task automatic read_data(input int addr, input string req);
        logic [31:0] d, e;
        e = (rx_q.size() != 0) ? {24'b0, rx_q.pop_front()} : 32'h0;
        if (model_cnt > 0) model_cnt--;
        apb_read(addr, d);
        check(req, d, e);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        check("R1 rx_space after reset", {28'b0, rx_space}, DEPTH);
        check("R1 irq/tx idle", {30'b0, irq, tx_valid}, 0);
        apb_read(4, d); check("R1 R7 status reset", d, 32'h6);
        apb_read(8, d); check("R1 control reset", d, 32'h0);

        apb_write(8, 32'hFFFF_FFF0); apb_read(8, d); check("R3 control full word", d, 32'hFFFF_FFF0);
        apb_write(8, 32'h0); apb_read(8, d); check("R3 control cleared", d, 32'h0);

        rx_burst(2, 8'hA0);
        apb_read(4, d); check("R4 disabled rx status", d, 32'h6);
        check("R4 disabled rx space", {28'b0, rx_space}, DEPTH);

        apb_write(8, 32'h5);
        rx_burst(3, 8'h10);
        check("R9 rx irq pulses", irq_seen, irq_exp);
        apb_read(4, d); check("R7 status ready", d, 32'h7);
        check("R10 space 5", {28'b0, rx_space}, 5);
        rx_burst(4, 8'h13);
        apb_read(4, d); check("R7 status half", d, 32'h107);
        rx_burst(2, 8'h50);
        check("R5 rejected burst space", {28'b0, rx_space}, 1);
        check("R5 R9 no irq on reject", irq_seen, irq_exp);
        rx_burst(1, 8'h17);
        apb_read(4, d); check("R7 status full", d, 32'h507);
        check("R10 space 0", {28'b0, rx_space}, 0);

        read_data(0, "R6 pop offset 0");
        read_data(3, "R2 R6 pop offset 3");
        for (int i = 0; i < 6; i++) read_data(0, "R6 pop order");
        apb_read(4, d); check("R6 R7 status drained", d, 32'h6);
        read_data(0, "R6 empty read zero");
        check("R6 empty read keeps space", {28'b0, rx_space}, DEPTH);

        apb_write(12, 32'h1234); apb_write(16, 32'h5678); apb_write(28, 32'h9);
        apb_read(12, d); check("R2 scaler reads zero", d, 0);
        apb_read(16, d); check("R2 debug reads zero", d, 0);
        apb_read(28, d); check("R2 unmapped reads zero", d, 0);
        apb_read(8, d); check("R2 control untouched", d, 32'h5);

        apb_write(0, 32'h41);
        apb_write(8, 32'hA);
        apb_write(0, 32'h1234_5642);
        apb_write(3, 32'h99);
        apb_write(8, 32'h2);
        apb_write(0, 32'h55);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 all tx delivered", tx_q.size(), 0);
        check("R9 tx irq pulses", irq_seen, irq_exp);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule